// File: doc/BRIEF.md
# Preamble-Regenerating Repeater Elasticity Buffer

This block sits on the transmit side of a multiport repeater, between the decoded receive stream of the active port and the retransmit path. Upstream transceivers lose some of the leading preamble bits of a frame. Once the active receive port has been chosen and `start` is pulsed, the block begins sending a fresh alternating preamble at once, without waiting for any received data. It sends a full 56-bit preamble and a delimiter byte, and only then releases the frame's data bits.

On the receive side the block watches the NRZ bit stream, its bit strobe and its enable. It discards everything up to the first pair of consecutive ones, which ends the received delimiter. Every later bit goes into a 32-bit elastic store. The transmit side drains the store at its own bit strobe, so small rate differences between the two sides are absorbed. A collision request makes the block drop the frame at any time and send a 1010 jam pattern instead.

Top module: `rep_elastic_buf`

## Requirements
- R1: After reset, `tx_data`, `tx_valid`, `ovf_err` and `unf_err` are all 0.
- R2: `start` is accepted only when the block is idle and `jam_req` is low. From the first `tx_clk_en` strobe after acceptance, each strobe emits one bit with `tx_valid` high, registered on the edge that ends the strobe cycle. The first 64 bits are 56 alternating bits beginning with 1, followed by the delimiter 1,0,1,0,1,0,1,1.
- R3: A received bit counts only in a cycle where `rx_clk_en` and `rx_en` are both high. Nothing is stored until the first two consecutive counted bits equal 1. Those two bits are not stored, and every counted bit after them is stored.
- R4: Stored bits appear on `tx_data` only after all 64 header bits. They appear in the order received, one per transmit strobe.
- R5: The store holds 32 bits. A counted bit that arrives while 32 bits are held is dropped, and `ovf_err` pulses high for one cycle.
- R6: In the data phase, a transmit strobe that finds the store empty before receive has ended pulses `unf_err` for one cycle and emits a 0 with `tx_valid` high.
- R7: Receive ends when `rx_en` falls after `start`. The first data-phase transmit strobe that then finds the store empty drops `tx_valid` and `tx_data` to 0 and empties the store, so the next frame starts clean.
- R8: `jam_req` high in any cycle discards the frame and empties the store. From the next transmit strobe the output is alternating bits beginning with 1. At least 96 jam bits are sent, and sending continues while `jam_req` is high at a strobe. The first strobe after that with `jam_req` low drops `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_clk_en | input | 1 | Receive bit strobe |
| rx_en | input | 1 | Receive enable (carrier of the active port) |
| rx_data | input | 1 | Decoded NRZ receive bit |
| start | input | 1 | Active receive port identified; begin regeneration |
| jam_req | input | 1 | Collision request; send the jam pattern |
| tx_clk_en | input | 1 | Transmit bit strobe |
| tx_data | output | 1 | NRZ transmit bit |
| tx_valid | output | 1 | Transmit bit valid |
| ovf_err | output | 1 | One-cycle pulse: received bit dropped, store full |
| unf_err | output | 1 | One-cycle pulse: store empty while data is still due |

## Verification
Every transmit bit is registered on the edge that ends its strobe cycle. The bench therefore samples `tx_data` and `tx_valid` at the falling edge one cycle after each strobe it drove, and compares the collected stream with a header, payload and jam sequence built arithmetically. Error pulses are registered one cycle after the bit that caused them. The bench ORs them at every falling edge, so none is missed. Frame-end checks are made only after the stream has gone invalid. Sweeps cover many received preamble lengths and payload lengths under two strobe rates, and separate runs force overflow, underflow, a short jam and a long jam.

// File: rtl/reb_pkg.sv
package reb_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HDR  = 2'd1,
        TX_DATA = 2'd2,
        TX_JAM  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HUNT = 2'd1,
        RX_DATA = 2'd2,
        RX_DONE = 2'd3
    } rx_state_e;
endpackage

// File: rtl/reb_rx_capture.sv
module reb_rx_capture
    import reb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_clk_en,
    input  logic rx_en,
    input  logic rx_data,
    input  logic frame_start,
    input  logic flush,
    output logic wr_en,
    output logic wr_data,
    output logic rx_done
);
    typedef struct packed {
        rx_state_e state;
        logic      prev_one;
        logic      en_seen;
    } rx_regs_t;

    rx_regs_t s_d, s_q;
    logic     bit_ok;
    logic     en_fall;

    assign bit_ok  = rx_clk_en && rx_en;
    assign en_fall = s_q.en_seen && !rx_en;

    always_comb begin
        s_d         = s_q;
        s_d.en_seen = rx_en;
        wr_en       = 1'b0;
        if (flush) begin
            s_d.state    = RX_IDLE;
            s_d.prev_one = 1'b0;
        end else begin
            unique case (s_q.state)
                RX_IDLE: begin
                    if (frame_start) begin
                        s_d.state    = RX_HUNT;
                        s_d.prev_one = 1'b0;
                    end
                end
                RX_HUNT: begin
                    if (en_fall) begin
                        s_d.state = RX_DONE;
                    end else if (bit_ok) begin
                        if (s_q.prev_one && rx_data) s_d.state = RX_DATA;
                        s_d.prev_one = rx_data;
                    end
                end
                RX_DATA: begin
                    if (en_fall) s_d.state = RX_DONE;
                    else if (bit_ok) wr_en = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: RX_IDLE, prev_one: 1'b0, en_seen: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_data = rx_data;
    assign rx_done = (s_q.state == RX_DONE);

    rx_state_e st_q;
    logic      prev_q;
    assign st_q   = s_q.state;
    assign prev_q = s_q.prev_one;

    // R3: the data phase opens only on a second consecutive counted one
    assert_sfd_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_DATA && $past(st_q) == RX_HUNT)
        |-> ($past(rx_data) && $past(prev_q) && $past(rx_clk_en) && $past(rx_en)));
endmodule

// File: rtl/reb_bit_fifo.sv
module reb_bit_fifo #(
    parameter int DEPTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic wr_en,
    input  logic wr_data,
    input  logic rd_en,
    output logic rd_data,
    output logic empty,
    output logic ovf_err
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    rd_ptr;
        logic [CW-1:0]    count;
        logic             ovf;
    } fifo_regs_t;

    fifo_regs_t s_d, s_q;
    logic       wr_ok;
    logic       rd_ok;

    assign wr_ok = wr_en && (s_q.count != FULL_C);
    assign rd_ok = rd_en && (s_q.count != '0);

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        if (flush) begin
            s_d.wr_ptr = '0;
            s_d.rd_ptr = '0;
            s_d.count  = '0;
        end else begin
            s_d.ovf = wr_en && !wr_ok;
            if (wr_ok) begin
                s_d.mem[s_q.wr_ptr] = wr_data;
                s_d.wr_ptr = (s_q.wr_ptr == LAST_C) ? '0 : s_q.wr_ptr + 1'b1;
            end
            if (rd_ok) begin
                s_d.rd_ptr = (s_q.rd_ptr == LAST_C) ? '0 : s_q.rd_ptr + 1'b1;
            end
            s_d.count = s_q.count + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.mem[s_q.rd_ptr];
    assign empty   = (s_q.count == '0);
    assign ovf_err = s_q.ovf;

    logic [CW-1:0] count_q;
    assign count_q = s_q.count;

    // R5: occupancy never passes the capacity
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_C);
    // R5: an overflow pulse follows only a full store
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> ($past(count_q) == FULL_C && $past(wr_en)));
    // R7: a flush leaves the store empty
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0));
endmodule

// File: rtl/reb_tx_seq.sv
module reb_tx_seq
    import reb_pkg::*;
#(
    parameter int PRE_BITS = 56,
    parameter int JAM_MIN  = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic jam_req,
    input  logic empty,
    input  logic rd_data,
    input  logic rx_done,
    output logic rd_en,
    output logic flush,
    output logic frame_start,
    output logic tx_data,
    output logic tx_valid,
    output logic unf_err
);
    localparam int HDR_LEN = PRE_BITS + 8;
    localparam int CNT_MAX = (HDR_LEN > JAM_MIN) ? HDR_LEN : JAM_MIN;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] HDR_LAST = CW'(HDR_LEN - 1);
    localparam logic [CW-1:0] SFD_TAIL = CW'(HDR_LEN - 2);
    localparam logic [CW-1:0] JAM_DONE = CW'(JAM_MIN);

    typedef struct packed {
        tx_state_e     state;
        logic [CW-1:0] cnt;
        logic          phase;
        logic          data;
        logic          valid;
        logic          unf;
    } tx_regs_t;

    tx_regs_t s_d, s_q;
    logic     hdr_bit;

    assign hdr_bit     = (s_q.cnt >= SFD_TAIL) ? 1'b1 : ~s_q.cnt[0];
    assign frame_start = start && !jam_req && (s_q.state == TX_IDLE);

    always_comb begin
        s_d     = s_q;
        s_d.unf = 1'b0;
        rd_en   = 1'b0;
        flush   = 1'b0;
        if (jam_req && s_q.state != TX_JAM) begin
            s_d.state = TX_JAM;
            s_d.cnt   = '0;
            s_d.phase = 1'b1;
            flush     = 1'b1;
        end else begin
            unique case (s_q.state)
                TX_IDLE: begin
                    if (frame_start) begin
                        s_d.state = TX_HDR;
                        s_d.cnt   = '0;
                    end
                end
                TX_HDR: begin
                    if (tick) begin
                        s_d.valid = 1'b1;
                        s_d.data  = hdr_bit;
                        if (s_q.cnt == HDR_LAST) begin
                            s_d.state = TX_DATA;
                            s_d.cnt   = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        if (!empty) begin
                            rd_en     = 1'b1;
                            s_d.data  = rd_data;
                            s_d.valid = 1'b1;
                        end else if (rx_done) begin
                            s_d.state = TX_IDLE;
                            s_d.data  = 1'b0;
                            s_d.valid = 1'b0;
                            flush     = 1'b1;
                        end else begin
                            s_d.unf   = 1'b1;
                            s_d.data  = 1'b0;
                            s_d.valid = 1'b1;
                        end
                    end
                end
                TX_JAM: begin
                    if (tick) begin
                        if (s_q.cnt == JAM_DONE && !jam_req) begin
                            s_d.state = TX_IDLE;
                            s_d.data  = 1'b0;
                            s_d.valid = 1'b0;
                        end else begin
                            s_d.data  = s_q.phase;
                            s_d.phase = ~s_q.phase;
                            s_d.valid = 1'b1;
                            if (s_q.cnt != JAM_DONE) s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: TX_IDLE, cnt: '0, phase: 1'b0, data: 1'b0,
                     valid: 1'b0, unf: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_data  = s_q.data;
    assign tx_valid = s_q.valid;
    assign unf_err  = s_q.unf;

    tx_state_e     st_q;
    logic [CW-1:0] cnt_q;
    assign st_q  = s_q.state;
    assign cnt_q = s_q.cnt;

    // R4: the data phase is entered only after the last header bit
    assert_hdr_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_DATA && $past(st_q) == TX_HDR) |-> ($past(cnt_q) == HDR_LAST));
    // R8: jam continues until the minimum count is reached
    assert_jam_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_JAM && cnt_q < JAM_DONE) |=> (st_q == TX_JAM));
    // R6: an underflow pulse comes only from the data phase
    assert_unf_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |-> ($past(st_q) == TX_DATA && $past(empty)));
    // R7: an invalid output carries a zero bit
    assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> !tx_data);
endmodule

// File: rtl/rep_elastic_buf.sv
module rep_elastic_buf #(
    parameter int DEPTH    = 32,
    parameter int PRE_BITS = 56,
    parameter int JAM_MIN  = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_clk_en,
    input  logic rx_en,
    input  logic rx_data,
    input  logic start,
    input  logic jam_req,
    input  logic tx_clk_en,
    output logic tx_data,
    output logic tx_valid,
    output logic ovf_err,
    output logic unf_err
);
    logic wr_en;
    logic wr_data;
    logic rd_en;
    logic rd_data;
    logic empty;
    logic flush;
    logic frame_start;
    logic rx_done;

    reb_rx_capture u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_clk_en   (rx_clk_en),
        .rx_en       (rx_en),
        .rx_data     (rx_data),
        .frame_start (frame_start),
        .flush       (flush),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rx_done     (rx_done)
    );

    reb_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .empty   (empty),
        .ovf_err (ovf_err)
    );

    reb_tx_seq #(.PRE_BITS(PRE_BITS), .JAM_MIN(JAM_MIN)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tx_clk_en),
        .start       (start),
        .jam_req     (jam_req),
        .empty       (empty),
        .rd_data     (rd_data),
        .rx_done     (rx_done),
        .rd_en       (rd_en),
        .flush       (flush),
        .frame_start (frame_start),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .unf_err     (unf_err)
    );
endmodule

// File: tb/rep_elastic_buf_tb.sv
module rep_elastic_buf_tb;
    localparam int HDR = 64;
    localparam int JMIN = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_clk_en = 1'b0, rx_en = 1'b0, rx_data = 1'b0;
    logic start = 1'b0, jam_req = 1'b0, tx_clk_en = 1'b0;
    logic tx_data, tx_valid, ovf_err, unf_err;

    int checks = 0;
    int errors = 0;
    bit rxbits [0:511];
    bit got    [0:1023];
    bit expv   [0:1023];
    int ngot;
    bit saw_ovf, saw_unf;

    always #10 clk = ~clk;

    rep_elastic_buf u_dut (
        .clk(clk), .rst_n(rst_n), .rx_clk_en(rx_clk_en), .rx_en(rx_en),
        .rx_data(rx_data), .start(start), .jam_req(jam_req),
        .tx_clk_en(tx_clk_en), .tx_data(tx_data), .tx_valid(tx_valid),
        .ovf_err(ovf_err), .unf_err(unf_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit pay(input int i, input int seed);
        return bit'(((i * 37 + seed * 11 + (i >> 2) * 5) >> 1) & 1);
    endfunction

    function automatic bit hdr_bit(input int i);
        return (i >= HDR - 2) ? 1'b1 : bit'((i % 2) == 0);
    endfunction

    task automatic run_frame(input int rxpre, input int plen, input int txp,
                             input int rxp, input int jam_at, input int jam_hold,
                             input int seed);
        int nbits = rxpre + 2 + plen;
        int t = 1, ri = 0, txcnt = 0, guard = 0;
        bit prev_tx = 0, seen = 0, txs, rxs;
        for (int i = 0; i < rxpre; i++) rxbits[i] = bit'((i % 2) == 0);
        rxbits[rxpre] = 1'b1;
        rxbits[rxpre + 1] = 1'b1;
        for (int i = 0; i < plen; i++) rxbits[rxpre + 2 + i] = pay(i, seed);
        ngot = 0; saw_ovf = 0; saw_unf = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (guard < 8000) begin
            if (ovf_err) saw_ovf = 1;
            if (unf_err) saw_unf = 1;
            if (prev_tx && tx_valid) begin
                got[ngot] = tx_data;
                ngot++;
                seen = 1;
            end
            if (seen && !tx_valid && ri >= nbits) break;
            txs = (t % txp) == 0;
            rxs = ((t % rxp) == 0) && (ri < nbits);
            jam_req   = (jam_at >= 0) && (txcnt >= jam_at) && (txcnt < jam_at + jam_hold);
            tx_clk_en = txs;
            rx_clk_en = rxs;
            rx_en     = ri < nbits;
            rx_data   = rxs ? rxbits[ri] : 1'b0;
            if (rxs) ri++;
            if (txs) txcnt++;
            prev_tx = txs;
            t++;
            guard++;
            @(negedge clk);
        end
        tx_clk_en = 0; rx_clk_en = 0; rx_en = 0; rx_data = 0; jam_req = 0;
        repeat (3) @(negedge clk);
        if (ovf_err) saw_ovf = 1;
        if (unf_err) saw_unf = 1;
    endtask

    task automatic check_frame(input int plen, input int seed, input string tag);
        int bad_h = -1, bad_p = -1;
        check(ngot == HDR + plen, "R4", {tag, " bit count"}, ngot, HDR + plen);
        for (int i = 0; i < HDR && i < ngot; i++)
            if (got[i] != hdr_bit(i) && bad_h < 0) bad_h = i;
        check(bad_h < 0, "R2", {tag, " header mismatch at bit"}, bad_h, -1);
        for (int i = 0; i < plen && HDR + i < ngot; i++)
            if (got[HDR + i] != pay(i, seed) && bad_p < 0) bad_p = i;
        check(bad_p < 0, "R3", {tag, " payload mismatch at bit"}, bad_p, -1);
        check(!saw_ovf && !saw_unf, "R5", {tag, " spurious error pulse"},
              int'(saw_ovf) * 2 + int'(saw_unf), 0);
        check(!tx_valid && !tx_data, "R7", {tag, " idle after drain"},
              int'(tx_valid) * 2 + int'(tx_data), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        int jl;
        repeat (3) @(negedge clk);
        check(tx_valid == 0 && tx_data == 0, "R1", "outputs in reset",
              int'(tx_valid) * 2 + int'(tx_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ovf_err == 0 && unf_err == 0, "R1", "error flags after reset",
              int'(ovf_err) * 2 + int'(unf_err), 0);
        check(tx_valid == 0, "R1", "valid after reset", int'(tx_valid), 0);

        // R2 R3 R4 R7: sweep received preamble length and payload length
        for (int k = 0; k < 15; k++) begin
            run_frame(32 + 2 * k, 8 + (k * 13) % 60, 2, 2, -1, 0, k);
            check_frame(8 + (k * 13) % 60, k, "sweep2");
        end
        for (int k = 0; k < 6; k++) begin
            run_frame(34 + 4 * k, 20 + 7 * k, 3, 3, -1, 0, 40 + k);
            check_frame(20 + 7 * k, 40 + k, "sweep3");
        end

        // R5: short received preamble fills the store before the header ends
        run_frame(4, 80, 2, 2, -1, 0, 7);
        check(saw_ovf, "R5", "overflow pulse seen", int'(saw_ovf), 1);
        check(!tx_valid, "R7", "idle after overflow frame", int'(tx_valid), 0);

        // R6: receive slower than transmit
        run_frame(40, 120, 2, 3, -1, 0, 9);
        check(saw_unf, "R6", "underflow pulse seen", int'(saw_unf), 1);
        check(!saw_ovf, "R6", "no overflow in slow-receive frame", int'(saw_ovf), 0);

        // recovery: clean frame after error frames
        run_frame(44, 30, 2, 2, -1, 0, 3);
        check_frame(30, 3, "after_errors");

        // R8: single-cycle jam during the header
        run_frame(40, 60, 2, 2, 10, 1, 5);
        jl = 10 + JMIN;
        check(ngot == jl, "R8", "short jam length", ngot, jl);
        bad = -1;
        for (int i = 0; i < jl && i < ngot; i++) begin
            expv[i] = (i < 10) ? hdr_bit(i) : bit'(((i - 10) % 2) == 0);
            if (got[i] != expv[i] && bad < 0) bad = i;
        end
        check(bad < 0, "R8", "short jam bit mismatch at", bad, -1);

        // R8: long jam during the data phase
        run_frame(40, 60, 2, 2, 80, 150, 6);
        jl = 80 + 150;
        check(ngot == jl, "R8", "long jam length", ngot, jl);
        bad = -1;
        for (int i = 0; i < jl && i < ngot; i++) begin
            if (i < HDR) expv[i] = hdr_bit(i);
            else if (i < 80) expv[i] = pay(i - HDR, 6);
            else expv[i] = bit'(((i - 80) % 2) == 0);
            if (got[i] != expv[i] && bad < 0) bad = i;
        end
        check(bad < 0, "R8", "long jam bit mismatch at", bad, -1);
        check(!tx_valid && !tx_data, "R7", "idle after jam",
              int'(tx_valid) * 2 + int'(tx_data), 0);

        // frame after jam starts clean
        run_frame(36, 25, 2, 2, -1, 0, 12);
        check_frame(25, 12, "after_jam");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule